// File: doc/BRIEF.md
# Dual-Rail Error Cascade with State Self-Erase

This block sits between the combinational core of a dual-rail datapath and the two places where that core's results become visible or persistent: the output port and the state register. Each logical bit travels as a pair of wires. The pair 10 means one, 01 means zero, and 00 is the error symbol. The block chains cascade cells over every pair the core hands over: the output pairs, the next-state pairs, copies of the input pairs and copies of the current memory pairs. If any one of these pairs reads 00, the cascade forces every output pair and every next-state pair to 00. The stored state is therefore wiped at the next clock. From then on the erased memory keeps feeding 00 back into the chain, so the block stays dark until reset.

The pairs enter the chain in a fixed order: the output-bound pairs at the top, the memory-bound pairs below them, then the input copies and the memory copies. A downward pass carries any error to the bottom of the chain and an upward pass carries it back to every kept position. An error arising on a memory-bound pair therefore zeroes the outputs in the same cycle as it appears. The block also contains the dual-rail state register, which a synchronous reset loads with an encoded parameter value, and a decoder that turns the cascaded output pairs back into plain bits.

Top module: `err_erase_top`

## Requirements
- R1: Pair encoding is {hi, lo}: 10 is logic one, 01 is logic zero and 00 is the error symbol. A decoded output bit `dout[i]` is 1 only when pair i of `out_pairs` is 10; the pairs 00, 01 and 11 all decode to 0.
- R2: When no driven or stored pair is 00, `out_pairs` equals `core_out` in the same cycle.
- R3: When no pair is 00 and reset is low, `mem_pairs` after the next rising edge equals the `core_nxt` value of the cycle before.
- R4: If any pair of `core_out`, `core_nxt`, `in_copy` or `mem_pairs` is 00, then every pair of `out_pairs` is 00 and `dout` is all zeros in that same cycle, whatever position the error has in the chain.
- R5: If any pair is 00 in a cycle with reset low, every pair of `mem_pairs` is 00 after the next rising edge.
- R6: Once `mem_pairs` is all 00, it stays all 00 and `dout` stays zero on every later cycle until reset, even with valid values on every input.
- R7: A synchronous reset loads `mem_pairs` with `RST_VAL` encoded pair by pair (bit i becomes pair i). Reset takes priority over an error present in the same cycle.
- R8: The pair 11 is not the error symbol. It passes through the cascade unchanged and does not erase memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| core_out | input | 2*N_OUT | Output-bound pairs from the core |
| core_nxt | input | 2*N_ST | Next-state pairs from the core |
| in_copy | input | 2*N_IN | Copies of the external input pairs |
| mem_pairs | output | 2*N_ST | Current state register pairs (also fed back into the chain) |
| out_pairs | output | 2*N_OUT | Cascaded output pairs |
| dout | output | N_OUT | Plain-bit decode of `out_pairs` |

## Verification
The bench builds the block with the default parameters: two output pairs, three state pairs, two input copies and a reset value of 101. These give a ten-position chain. At this size every combination of clean output and next-state values can be applied. The error symbol can also be injected at each of the seven driven chain positions in turn, and each injection is followed from the cycle in which it zeroes the outputs through the wipe at the next edge and on into the erased state. Each injection also runs through the fed-back memory positions, and the case where an error meets an active reset is exercised as well.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef logic [1:0] pair_t;

  localparam pair_t PAIR_ERR  = 2'b00;
  localparam pair_t PAIR_ONE  = 2'b10;
  localparam pair_t PAIR_ZERO = 2'b01;

  function automatic logic pair_err(input pair_t p);
    return (p == PAIR_ERR);
  endfunction

  function automatic pair_t pair_enc(input logic v);
    return v ? PAIR_ONE : PAIR_ZERO;
  endfunction

  function automatic logic pair_dec(input pair_t p);
    return (p == PAIR_ONE);
  endfunction
endpackage

// File: rtl/dr_cell.sv
// Two-in, two-out cascade cell: an error on either side blanks both sides.
module dr_cell
  import dr_pkg::*;
(
  input  pair_t a,
  input  pair_t b,
  output pair_t ya,
  output pair_t yb
);
  logic hit;
  assign hit = pair_err(a) | pair_err(b);
  assign ya  = hit ? PAIR_ERR : a;
  assign yb  = hit ? PAIR_ERR : b;
endmodule

// File: rtl/dr_relay.sv
// Single-output variant for positions whose value is discarded.
module dr_relay
  import dr_pkg::*;
(
  input  pair_t a,
  input  pair_t b,
  output pair_t ya
);
  assign ya = (pair_err(a) | pair_err(b)) ? PAIR_ERR : a;
endmodule

// File: rtl/dr_cascade.sv
// Down pass gathers any error at the bottom, up pass returns it to the top.
module dr_cascade
  import dr_pkg::*;
#(
  parameter int M    = 10,
  parameter int KEEP = 5
) (
  input  logic [2*M-1:0]    pin,
  output logic [2*KEEP-1:0] pout,
  output logic              sweep_err
);
  pair_t p [M];
  pair_t s [M];
  pair_t h [M-1];
  pair_t r [M];
  pair_t f [KEEP];

  for (genvar k = 0; k < M; k++) begin : g_split
    assign p[k] = pin[2*k +: 2];
  end

  assign s[0] = p[0];
  for (genvar k = 1; k < M; k++) begin : g_down
    dr_cell u_dn (.a(s[k-1]), .b(p[k]), .ya(h[k-1]), .yb(s[k]));
  end

  assign r[M-1] = s[M-1];
  for (genvar k = M - 1; k >= 1; k--) begin : g_up
    if (k < KEEP) begin : g_keep
      dr_cell u_up (.a(h[k-1]), .b(r[k]), .ya(r[k-1]), .yb(f[k]));
    end else begin : g_drop
      dr_relay u_rl (.a(h[k-1]), .b(r[k]), .ya(r[k-1]));
    end
  end
  assign f[0] = r[0];

  for (genvar k = 0; k < KEEP; k++) begin : g_join
    assign pout[2*k +: 2] = f[k];
  end

  assign sweep_err = pair_err(s[M-1]);
endmodule

// File: rtl/dr_state_reg.sv
module dr_state_reg
  import dr_pkg::*;
#(
  parameter int             N       = 3,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] d,
  output logic [2*N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) q[2*i +: 2] <= pair_enc(RST_VAL[i]);
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/dr_decode.sv
module dr_decode
  import dr_pkg::*;
#(
  parameter int N = 2
) (
  input  logic [2*N-1:0] pairs,
  output logic [N-1:0]   bits
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign bits[i] = pair_dec(pairs[2*i +: 2]);
  end
endmodule

// File: rtl/err_erase_top.sv
module err_erase_top #(
  parameter int              N_OUT   = 2,
  parameter int              N_ST    = 3,
  parameter int              N_IN    = 2,
  parameter logic [N_ST-1:0] RST_VAL = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*N_OUT-1:0] core_out,
  input  logic [2*N_ST-1:0]  core_nxt,
  input  logic [2*N_IN-1:0]  in_copy,
  output logic [2*N_ST-1:0]  mem_pairs,
  output logic [2*N_OUT-1:0] out_pairs,
  output logic [N_OUT-1:0]   dout
);
  localparam int M    = N_OUT + 2 * N_ST + N_IN;
  localparam int KEEP = N_OUT + N_ST;

  logic [2*M-1:0]    chain_in;
  logic [2*KEEP-1:0] chain_out;
  logic [2*N_ST-1:0] mem_d;
  logic              sweep_err;

  // Position 0 is the top of the chain: outputs, then memory-bound, then copies.
  assign chain_in = {mem_pairs, in_copy, core_nxt, core_out};

  dr_cascade #(.M(M), .KEEP(KEEP)) u_casc (
    .pin      (chain_in),
    .pout     (chain_out),
    .sweep_err(sweep_err)
  );

  assign out_pairs = chain_out[0 +: 2*N_OUT];
  assign mem_d     = chain_out[2*N_OUT +: 2*N_ST];

  dr_state_reg #(.N(N_ST), .RST_VAL(RST_VAL)) u_mem (
    .clk(clk), .rst(rst), .d(mem_d), .q(mem_pairs)
  );

  dr_decode #(.N(N_OUT)) u_dec (.pairs(out_pairs), .bits(dout));
endmodule

// File: rtl/err_erase_chk.sv
module err_erase_chk #(
  parameter int              N_OUT   = 2,
  parameter int              N_ST    = 3,
  parameter int              N_IN    = 2,
  parameter logic [N_ST-1:0] RST_VAL = 3'b101
) (
  input logic               clk,
  input logic               rst,
  input logic [2*N_OUT-1:0] core_out,
  input logic [2*N_ST-1:0]  core_nxt,
  input logic [2*N_IN-1:0]  in_copy,
  input logic [2*N_ST-1:0]  mem_pairs,
  input logic [2*N_OUT-1:0] out_pairs,
  input logic [N_OUT-1:0]   dout,
  input logic               sweep_err
);
  localparam int W = 2 * (N_OUT + 2 * N_ST + N_IN);
  logic [W-1:0]      all_p;
  logic              any_err;
  logic [2*N_ST-1:0] rst_img;

  assign all_p = {mem_pairs, in_copy, core_nxt, core_out};

  always_comb begin
    any_err = 1'b0;
    for (int i = 0; i < W / 2; i++)
      if (all_p[2*i +: 2] == 2'b00) any_err = 1'b1;
    for (int i = 0; i < N_ST; i++) rst_img[2*i +: 2] = {RST_VAL[i], ~RST_VAL[i]};
  end

  assert_clean_pass_R2: assert property (@(posedge clk) disable iff (rst)
    !any_err |-> out_pairs == core_out);
  assert_clean_load_R3: assert property (@(posedge clk) disable iff (rst)
    !any_err |=> mem_pairs == $past(core_nxt));
  assert_same_cycle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    any_err |-> (out_pairs == '0 && dout == '0));
  assert_sweep_flag_R4: assert property (@(posedge clk) disable iff (rst)
    sweep_err == any_err);
  assert_wipe_next_R5: assert property (@(posedge clk) disable iff (rst)
    any_err |=> mem_pairs == '0);
  assert_stay_erased_R6: assert property (@(posedge clk) disable iff (rst)
    mem_pairs == '0 |=> (mem_pairs == '0 && dout == '0));
  assert_reset_load_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> mem_pairs == rst_img);
endmodule

bind err_erase_top err_erase_chk #(
  .N_OUT(N_OUT), .N_ST(N_ST), .N_IN(N_IN), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .rst(rst), .core_out(core_out), .core_nxt(core_nxt),
  .in_copy(in_copy), .mem_pairs(mem_pairs), .out_pairs(out_pairs),
  .dout(dout), .sweep_err(sweep_err)
);

// File: tb/sim_err_erase_top.sv
module sim_err_erase_top;
  localparam int NO = 2, NS = 3, NI = 2;
  localparam logic [NS-1:0] RV = 3'b101;
  localparam int ND = NO + NS + NI;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*NO-1:0] c_out = '0;
  logic [2*NS-1:0] c_nxt = '0;
  logic [2*NI-1:0] c_in  = '0;
  logic [2*NS-1:0] mem_pairs;
  logic [2*NO-1:0] out_pairs;
  logic [NO-1:0]   dout;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  err_erase_top #(.N_OUT(NO), .N_ST(NS), .N_IN(NI), .RST_VAL(RV)) u0 (
    .clk(clk), .rst(rst), .core_out(c_out), .core_nxt(c_nxt), .in_copy(c_in),
    .mem_pairs(mem_pairs), .out_pairs(out_pairs), .dout(dout)
  );

  // Bit value v maps to hi rail v, lo rail not v.
  function automatic logic [15:0] mk(input logic [7:0] v, input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) begin
      r[2*i+1] = v[i];
      r[2*i]   = !v[i];
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_clean(input logic [7:0] o, input logic [7:0] n, input logic [7:0] x);
    c_out = mk(o, NO)[2*NO-1:0];
    c_nxt = mk(n, NS)[2*NS-1:0];
    c_in  = mk(x, NI)[2*NI-1:0];
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check(mem_pairs == mk(RV, NS)[2*NS-1:0], "R7", 16'(mem_pairs), mk(RV, NS));
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    drive_clean(8'h0, 8'h0, 8'h0);
    repeat (2) @(posedge clk);
    do_reset();

    // R1 R2 R3: every clean output and next-state combination
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 8; n++) begin
        drive_clean(8'(o), 8'(n), 8'(o ^ n));
        #1;
        check(out_pairs == mk(8'(o), NO)[2*NO-1:0], "R2", 16'(out_pairs), mk(8'(o), NO));
        check(dout == 2'(o), "R1", 16'(dout), 16'(o));
        @(posedge clk); #1;
        check(mem_pairs == mk(8'(n), NS)[2*NS-1:0], "R3", 16'(mem_pairs), mk(8'(n), NS));
        @(negedge clk);
      end
    end

    // R4 R5 R6: error symbol at each driven chain position
    for (int p = 0; p < ND; p++) begin
      logic [2*ND-1:0] v;
      do_reset();
      drive_clean(8'h1, 8'h6, 8'h2);
      v = {c_in, c_nxt, c_out};
      v[2*p +: 2] = 2'b00;
      {c_in, c_nxt, c_out} = v;
      #1;
      check(out_pairs == '0, "R4", 16'(out_pairs), 16'h0);
      check(dout == '0, "R4", 16'(dout), 16'h0);
      @(posedge clk); #1;
      check(mem_pairs == '0, "R5", 16'(mem_pairs), 16'h0);
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        drive_clean(8'(c + 1), 8'(7 - c), 8'(c));
        #1;
        check(dout == '0, "R6", 16'(dout), 16'h0);
        check(out_pairs == '0, "R6", 16'(out_pairs), 16'h0);
        @(posedge clk); #1;
        check(mem_pairs == '0, "R6", 16'(mem_pairs), 16'h0);
      end
      @(negedge clk);
    end

    // R8: pair 11 is a value, not an error
    do_reset();
    drive_clean(8'h2, 8'h3, 8'h1);
    c_out[1:0] = 2'b11;
    #1;
    check(out_pairs == {2'b10, 2'b11}, "R8", 16'(out_pairs), 16'h0b);
    check(dout == 2'b10, "R1", 16'(dout), 16'h2);
    @(posedge clk); #1;
    check(mem_pairs == mk(8'h3, NS)[2*NS-1:0], "R8", 16'(mem_pairs), mk(8'h3, NS));

    // R7: reset wins over an error in the same cycle
    @(negedge clk);
    drive_clean(8'h3, 8'h0, 8'h0);
    c_nxt[3:2] = 2'b00;
    rst = 1'b1;
    @(posedge clk); #1;
    check(mem_pairs == mk(RV, NS)[2*NS-1:0], "R7", 16'(mem_pairs), mk(RV, NS));
    @(negedge clk);
    rst = 1'b0;
    drive_clean(8'h3, 8'h4, 8'h0);
    #1;
    check(dout == 2'b11, "R2", 16'(dout), 16'h3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule